// File: doc/BRIEF.md
# HMAC-SHA-256 Stage Sequencer

This block computes a keyed message authentication code (HMAC with SHA-256) by driving an external SHA-256 block-compression core. It takes a key and a text as a stream of 32-bit words. It builds the padded inner and outer key blocks and feeds every 512-bit block to the core together with the chaining state that block starts from. It also keeps the midstates that let a later code under the same key skip all key work.

The work runs as five hash stages in a fixed order: long-key digest, inner key block, text blocks, outer key block and final block. Stages that are not needed are left out. The caller supplies text blocks that are already padded. The controller builds the final block itself from the inner digest. The core is loaded and read in parallel: a 512-bit block and a 256-bit start state go out with a one-cycle go strobe, and the 256-bit result comes back with a one-cycle done strobe.

Top module: `hmac_sequencer`

## Requirements
- R1: While reset is held, and after it is released, `done`, `coreGo` and `wordReady` are low and `mac` is all zeros.
- R2: With `keyLong` low, a key that ends with `inLast` before the sixteenth word is filled with zero words to 512 bits (word 0 occupies bits 511:480) to form the padded key. The inner block is that key XOR byte 0x36 in every byte, and it is hashed from the SHA-256 initial state.
- R3: A key of exactly sixteen words (the block ends at the sixteenth word) is used unchanged as the padded key.
- R4: With `keyLong` high, the key words are caller-padded message blocks. They are hashed block by block from the initial state, each block starting from the previous result. The padded key is {digest, 256 zero bits}.
- R5: A block of the word stream ends at its sixteenth word or at a word flagged `inLast`, and unfilled words are zero. The first text block starts from the inner midstate, and each later text block starts from the previous result.
- R6: After the last text result, the outer block (padded key XOR byte 0x5C in every byte) is hashed from the initial state.
- R7: The final block is {inner digest, 8'h80, 184 zero bits, 64-bit length 768}, hashed from the outer midstate. `mac` is its full 256-bit result.
- R8: `done` is high for exactly one cycle, in the cycle after `coreDone` returns the final result. `mac` is valid in that cycle and holds until the next `done`.
- R9: With `keyReuse` high at start, no key words are taken. Only the text blocks and the final block are issued, starting from the midstates saved by the last keyed run.
- R10: A `start` that arrives while a computation is running has no effect: the request sequence and the single `done` are unchanged.
- R11: `coreGo` is a one-cycle pulse. For a text block or long-key block it comes in the cycle right after the word that completes the block is accepted. `wordReady` stays low while the core is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation (taken only when idle) |
| keyLong | input | 1 | Key is longer than one block and must be hashed first |
| keyReuse | input | 1 | Reuse the saved midstates, no key is sent |
| inValid | input | 1 | `inWord` carries a key or text word |
| inWord | input | 32 | Key or text word, most significant word of the block first |
| inLast | input | 1 | Marks the final word of the key or of the text |
| wordReady | output | 1 | Word accepted on this edge when `inValid` is high |
| done | output | 1 | One-cycle completion pulse |
| mac | output | 256 | Authentication code |
| coreGo | output | 1 | Start the core on `coreBlock` and `coreInit` |
| coreBlock | output | 512 | Block handed to the core |
| coreInit | output | 256 | Chaining state the block starts from |
| coreDone | input | 1 | Core result valid (one cycle) |
| coreDigest | input | 256 | Core result state |

## Verification
A block-completing text or long-key word must give `coreGo` at the first falling edge after the rising edge that accepted it. A short or exact key adds one cycle for loading the padded key. `done` is due exactly one cycle after the stand-in core raises `coreDone` for the final block. The bench samples every output at the falling edge and compares `done` on every cycle with that one-cycle expectation. Each `coreGo` is matched against a queue of expected blocks and start states worked out behaviourally. The stand-in core answers after a delay that each run sets differently, so the handshake timing is exercised at several spacings.

// File: rtl/hmac_seq_pkg.sv
`timescale 1ns/1ps
package hmac_seq_pkg;
  localparam int WORD_W    = 32;
  localparam int BLK_WORDS = 16;
  localparam int DIG_W     = 256;
  localparam int IDX_W     = $clog2(BLK_WORDS);

  localparam logic [255:0] SHA_IV =
    256'h6a09e667_bb67ae85_3c6ef372_a54ff53a_510e527f_9b05688c_1f83d9ab_5be0cd19;

  typedef enum logic [2:0] {
    ST_KEYIN, ST_NKEY, ST_IPAD, ST_TEXT, ST_OPAD, ST_MAC
  } stage_e;

  typedef struct packed {
    logic             clrBuf;
    logic             wrWord;
    logic [IDX_W-1:0] wrIdx;
    logic             ldK0;
    logic             k0FromDigest;
    logic             chainIv;
    logic             chainIpad;
    logic             chainDigest;
    logic             capIpad;
    logic             capOpad;
    logic             capInner;
    logic             capMac;
    stage_e           stage;
  } dpCtl_t;
endpackage

// File: rtl/hmac_seq_dp.sv
`timescale 1ns/1ps
module hmac_seq_dp
  import hmac_seq_pkg::*;
#(
  parameter int WORD_WIDTH = WORD_W,
  parameter int NUM_WORDS  = BLK_WORDS,
  parameter int DIG_WIDTH  = DIG_W
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  dpCtl_t                            ctl,
  input  logic [WORD_WIDTH-1:0]             inWord,
  input  logic [DIG_WIDTH-1:0]              coreDigest,
  output logic [WORD_WIDTH*NUM_WORDS-1:0]   coreBlock,
  output logic [DIG_WIDTH-1:0]              coreInit,
  output logic [DIG_WIDTH-1:0]              mac
);
  localparam int BLK_W = WORD_WIDTH * NUM_WORDS;
  localparam int LEN_W = 64;
  localparam int PAD_Z = BLK_W - DIG_WIDTH - 8 - LEN_W;
  localparam logic [BLK_W-1:0] IPAD_BLK = {(BLK_W/8){8'h36}};
  localparam logic [BLK_W-1:0] OPAD_BLK = {(BLK_W/8){8'h5c}};
  localparam logic [LEN_W-1:0] MSG_BITS = LEN_W'(BLK_W + DIG_WIDTH);

  logic [BLK_W-1:0]     blkBuf;
  logic [BLK_W-1:0]     k0Reg;
  logic [DIG_WIDTH-1:0] chainReg;
  logic [DIG_WIDTH-1:0] ipadMid;
  logic [DIG_WIDTH-1:0] opadMid;   // also parks a long key's digest
  logic [DIG_WIDTH-1:0] innerReg;
  logic [DIG_WIDTH-1:0] macReg;
  logic [BLK_W-1:0]     finalBlk;

  // one register slot per word of the assembly buffer
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN || ctl.clrBuf)
        blkBuf[BLK_W-1-w*WORD_WIDTH -: WORD_WIDTH] <= '0;
      else if (ctl.wrWord && (ctl.wrIdx == w[IDX_W-1:0]))
        blkBuf[BLK_W-1-w*WORD_WIDTH -: WORD_WIDTH] <= inWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      k0Reg    <= '0;
      chainReg <= '0;
      ipadMid  <= '0;
      opadMid  <= '0;
      innerReg <= '0;
      macReg   <= '0;
    end else begin
      if (ctl.ldK0)
        k0Reg <= ctl.k0FromDigest ? {opadMid, {(BLK_W-DIG_WIDTH){1'b0}}} : blkBuf;
      if (ctl.chainIv)          chainReg <= SHA_IV[DIG_WIDTH-1:0];
      else if (ctl.chainIpad)   chainReg <= ipadMid;
      else if (ctl.chainDigest) chainReg <= coreDigest;
      if (ctl.capIpad)  ipadMid  <= coreDigest;
      if (ctl.capOpad)  opadMid  <= coreDigest;
      if (ctl.capInner) innerReg <= coreDigest;
      if (ctl.capMac)   macReg   <= coreDigest;
    end
  end

  assign finalBlk = {innerReg, 8'h80, {PAD_Z{1'b0}}, MSG_BITS};

  always_comb begin
    unique case (ctl.stage)
      ST_IPAD: begin coreBlock = k0Reg ^ IPAD_BLK; coreInit = SHA_IV[DIG_WIDTH-1:0]; end
      ST_OPAD: begin coreBlock = k0Reg ^ OPAD_BLK; coreInit = SHA_IV[DIG_WIDTH-1:0]; end
      ST_MAC:  begin coreBlock = finalBlk;         coreInit = opadMid;               end
      default: begin coreBlock = blkBuf;           coreInit = chainReg;              end
    endcase
  end

  assign mac = macReg;
endmodule

// File: rtl/hmac_seq_ctl.sv
`timescale 1ns/1ps
module hmac_seq_ctl
  import hmac_seq_pkg::*;
#(
  parameter int NUM_WORDS = BLK_WORDS
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   keyLong,
  input  logic   keyReuse,
  input  logic   inValid,
  input  logic   inLast,
  input  logic   coreDone,
  output logic   wordReady,
  output logic   coreGo,
  output logic   done,
  output dpCtl_t ctl
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  typedef enum logic [2:0] {C_IDLE, C_FILL, C_LDK0, C_ISSUE, C_WAIT} cstate_e;

  cstate_e          cState, nState;
  stage_e           stage, nStage;
  logic [IDX_W-1:0] wordCnt, nCnt;
  logic             sawLast, nLast;
  logic             longQ, nLong;
  logic             reuseQ, nReuse;
  logic             doneQ, finishNow;

  always_comb begin
    nState = cState;  nStage = stage;  nCnt = wordCnt;
    nLast  = sawLast; nLong  = longQ;  nReuse = reuseQ;
    finishNow = 1'b0;
    ctl = '0;
    ctl.stage = stage;
    ctl.wrIdx = wordCnt;
    unique case (cState)
      C_IDLE: if (start) begin
        nLong = keyLong; nReuse = keyReuse;
        nCnt = '0; nLast = 1'b0;
        ctl.clrBuf = 1'b1;
        nState = C_FILL;
        if (keyReuse) begin
          ctl.chainIpad = 1'b1; nStage = ST_TEXT;
        end else if (keyLong) begin
          ctl.chainIv = 1'b1;   nStage = ST_NKEY;
        end else begin
          nStage = ST_KEYIN;
        end
      end
      C_FILL: if (inValid) begin
        ctl.wrWord = 1'b1;
        nCnt = wordCnt + 1'b1;
        if (inLast) nLast = 1'b1;
        if (wordCnt == LAST_IDX || inLast)
          nState = (stage == ST_KEYIN) ? C_LDK0 : C_ISSUE;
      end
      C_LDK0: begin
        ctl.ldK0 = 1'b1;
        ctl.k0FromDigest = longQ;
        ctl.clrBuf = 1'b1;
        nStage = ST_IPAD;
        nState = C_ISSUE;
      end
      C_ISSUE: begin
        ctl.clrBuf = 1'b1;
        nState = C_WAIT;
      end
      C_WAIT: if (coreDone) begin
        unique case (stage)
          ST_NKEY: begin
            ctl.chainDigest = 1'b1;
            if (sawLast) begin
              ctl.capOpad = 1'b1; nState = C_LDK0;
            end else begin
              nCnt = '0; nState = C_FILL;
            end
          end
          ST_IPAD: begin
            ctl.capIpad = 1'b1; ctl.chainDigest = 1'b1;
            nStage = ST_TEXT; nCnt = '0; nLast = 1'b0; nState = C_FILL;
          end
          ST_TEXT: begin
            ctl.chainDigest = 1'b1;
            if (sawLast) begin
              ctl.capInner = 1'b1;
              nStage = reuseQ ? ST_MAC : ST_OPAD;
              nState = C_ISSUE;
            end else begin
              nCnt = '0; nState = C_FILL;
            end
          end
          ST_OPAD: begin
            ctl.capOpad = 1'b1; nStage = ST_MAC; nState = C_ISSUE;
          end
          ST_MAC: begin
            ctl.capMac = 1'b1; finishNow = 1'b1; nState = C_IDLE;
          end
          default: nState = C_IDLE;
        endcase
      end
      default: nState = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cState  <= C_IDLE;
      stage   <= ST_KEYIN;
      wordCnt <= '0;
      sawLast <= 1'b0;
      longQ   <= 1'b0;
      reuseQ  <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      cState  <= nState;
      stage   <= nStage;
      wordCnt <= nCnt;
      sawLast <= nLast;
      longQ   <= nLong;
      reuseQ  <= nReuse;
      doneQ   <= finishNow;
    end
  end

  assign wordReady = (cState == C_FILL);
  assign coreGo    = (cState == C_ISSUE);
  assign done      = doneQ;
endmodule

// File: rtl/hmac_sequencer.sv
`timescale 1ns/1ps
module hmac_sequencer
  import hmac_seq_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic                       keyLong,
  input  logic                       keyReuse,
  input  logic                       inValid,
  input  logic [WORD_W-1:0]          inWord,
  input  logic                       inLast,
  output logic                       wordReady,
  output logic                       done,
  output logic [DIG_W-1:0]           mac,
  output logic                       coreGo,
  output logic [WORD_W*BLK_WORDS-1:0] coreBlock,
  output logic [DIG_W-1:0]           coreInit,
  input  logic                       coreDone,
  input  logic [DIG_W-1:0]           coreDigest
);
  dpCtl_t ctl;

  hmac_seq_ctl #(.NUM_WORDS(BLK_WORDS)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .keyLong(keyLong),
    .keyReuse(keyReuse), .inValid(inValid), .inLast(inLast),
    .coreDone(coreDone), .wordReady(wordReady), .coreGo(coreGo),
    .done(done), .ctl(ctl)
  );

  hmac_seq_dp #(.WORD_WIDTH(WORD_W), .NUM_WORDS(BLK_WORDS), .DIG_WIDTH(DIG_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inWord(inWord),
    .coreDigest(coreDigest), .coreBlock(coreBlock), .coreInit(coreInit),
    .mac(mac)
  );
endmodule

// File: rtl/hmac_sequencer_chk.sv
`timescale 1ns/1ps
module hmac_sequencer_chk (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         wordReady,
  input logic         done,
  input logic [255:0] mac,
  input logic         coreGo,
  input logic         coreDone
);
  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: completion only follows a core result
  p_done_follows_core_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(coreDone));

  // R8: the code only moves together with completion
  p_mac_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (done || $stable(mac)));

  // R11: core start is a single-cycle pulse
  p_go_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    coreGo |=> !coreGo);

  // R10: a start seen while a block is being issued does not reopen input
  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    (start && coreGo) |=> (!wordReady && !coreGo));
endmodule

bind hmac_sequencer hmac_sequencer_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .wordReady(wordReady),
  .done(done), .mac(mac), .coreGo(coreGo), .coreDone(coreDone)
);

// File: tb/hmac_sequencer_bench.sv
`timescale 1ns/1ps
module hmac_sequencer_bench;
  localparam logic [255:0] IV0 =
    256'h6a09e667_bb67ae85_3c6ef372_a54ff53a_510e527f_9b05688c_1f83d9ab_5be0cd19;

  logic clk = 1'b0, rstN = 1'b0;
  logic start = 0, keyLong = 0, keyReuse = 0, inValid = 0, inLast = 0;
  logic [31:0]  inWord = '0;
  logic         wordReady, done, coreGo;
  logic [255:0] mac, coreInit;
  logic [511:0] coreBlock;
  logic         coreDone = 0;
  logic [255:0] coreDigest = '0;

  always #2.5 clk = ~clk;

  hmac_sequencer u_hmac_sequencer (
    .clk(clk), .rstN(rstN), .start(start), .keyLong(keyLong), .keyReuse(keyReuse),
    .inValid(inValid), .inWord(inWord), .inLast(inLast), .wordReady(wordReady),
    .done(done), .mac(mac), .coreGo(coreGo), .coreBlock(coreBlock),
    .coreInit(coreInit), .coreDone(coreDone), .coreDigest(coreDigest)
  );

  int checks = 0, errors = 0;
  logic [511:0] expBlk[$];
  logic [255:0] expInit[$];
  string        expTag[$];
  logic [31:0]  keyWords[$];
  logic [31:0]  textWords[$];
  logic [255:0] mdlIpad, mdlOpad, expMac, prevMac;
  int  coreLat = 3;
  int  doneCnt = 0;
  bit  opFinished = 0, havePrev = 0;

  // stand-in compression: any fixed keyed mix will do
  function automatic logic [255:0] fakeComp(logic [255:0] h, logic [511:0] b);
    logic [31:0] w;
    for (int i = 0; i < 16; i++) begin
      w = b[511-32*i -: 32];
      h = ({h[223:0], h[255:224]} ^ {8{w}}) + {8{w + 32'(i)}};
    end
    return h;
  endfunction

  task automatic check(bit ok, string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // core stand-in and per-cycle comparison
  int  busyCnt = 0;
  bit  busy = 0, dueDone = 0, lastReq = 0;
  logic [255:0] pendDig;
  always @(negedge clk) begin
    if (rstN) begin
      check(done === dueDone, "R8", 512'(done), 512'(dueDone));
      if (done) begin
        doneCnt++;
        check(mac === expMac, "R7", 512'(mac), 512'(expMac));
        opFinished = 1;
      end
      dueDone = 0;
      coreDone <= 1'b0;
      if (busy) begin
        busyCnt--;
        if (busyCnt == 0) begin
          busy = 0;
          coreDone <= 1'b1;
          coreDigest <= pendDig;
          dueDone = lastReq;
        end
      end
      if (coreGo) begin
        check(!busy, "R11", 512'(busy), 512'(0));
        if (expBlk.size() == 0) begin
          check(0, "R10", coreBlock, '0);
        end else begin
          check(coreBlock === expBlk[0], expTag[0], coreBlock, expBlk[0]);
          check(coreInit === expInit[0], expTag[0], 512'(coreInit), 512'(expInit[0]));
          pendDig = fakeComp(expInit[0], expBlk[0]);
          void'(expBlk.pop_front()); void'(expInit.pop_front()); void'(expTag.pop_front());
          lastReq = (expBlk.size() == 0);
          busy = 1; busyCnt = coreLat;
        end
      end
    end
  end

  function automatic logic [511:0] packBlk(ref logic [31:0] q[$], input int base);
    logic [511:0] b = '0;
    for (int i = 0; i < 16; i++)
      if (base + i < q.size()) b[511-32*i -: 32] = q[base + i];
    return b;
  endfunction

  task automatic buildModel(bit reuse, bit lng, bit exact);
    logic [255:0] ch;
    logic [511:0] k0, blk, fin;
    if (!reuse) begin
      if (lng) begin
        ch = IV0;
        for (int b = 0; b < (keyWords.size() + 15) / 16; b++) begin
          blk = packBlk(keyWords, b * 16);
          expBlk.push_back(blk); expInit.push_back(ch); expTag.push_back("R4");
          ch = fakeComp(ch, blk);
        end
        k0 = {ch, 256'b0};
      end else begin
        k0 = packBlk(keyWords, 0);
      end
      blk = k0 ^ {64{8'h36}};
      expBlk.push_back(blk); expInit.push_back(IV0);
      expTag.push_back(exact ? "R3" : (lng ? "R4" : "R2"));
      mdlIpad = fakeComp(IV0, blk);
      mdlOpad = fakeComp(IV0, k0 ^ {64{8'h5c}});
    end
    ch = mdlIpad;
    for (int b = 0; b < (textWords.size() + 15) / 16; b++) begin
      blk = packBlk(textWords, b * 16);
      expBlk.push_back(blk); expInit.push_back(ch); expTag.push_back(reuse ? "R9" : "R5");
      ch = fakeComp(ch, blk);
    end
    if (!reuse) begin
      expBlk.push_back(k0 ^ {64{8'h5c}}); expInit.push_back(IV0); expTag.push_back("R6");
    end
    fin = {ch, 8'h80, 184'b0, 64'd768};
    expBlk.push_back(fin); expInit.push_back(mdlOpad); expTag.push_back("R7");
    expMac = fakeComp(mdlOpad, fin);
  endtask

  task automatic sendWord(logic [31:0] w, bit last, bit chkGo);
    bit rdy;
    inWord = w; inLast = last; inValid = 1;
    do begin rdy = wordReady; @(negedge clk); end while (!rdy);
    inValid = 0; inLast = 0;
    if (chkGo) check(coreGo === 1'b1, "R11", 512'(coreGo), 512'(1));
  endtask

  task automatic runOp(bit reuse, bit lng, int nKey, int nText, int lat, bit busyStart, int seed);
    int guard = 0;
    keyWords.delete(); textWords.delete();
    for (int i = 0; i < nKey; i++)  keyWords.push_back(32'(seed * 977 + i * 131 + 7));
    for (int i = 0; i < nText; i++) textWords.push_back(32'(seed * 613 + i * 59 + 3) ^ 32'hA5A5_0000);
    if (havePrev) check(mac === prevMac, "R8", 512'(mac), 512'(prevMac));
    coreLat = lat;
    buildModel(reuse, lng, !lng && nKey == 16);
    opFinished = 0; doneCnt = 0;
    start = 1; keyLong = lng; keyReuse = reuse;
    @(negedge clk);
    start = 0; keyLong = 0; keyReuse = 0;
    if (!reuse)
      for (int i = 0; i < nKey; i++)
        sendWord(keyWords[i], i == nKey - 1, lng && (i % 16 == 15));
    for (int i = 0; i < nText; i++) begin
      sendWord(textWords[i], i == nText - 1, i % 16 == 15);
      if (busyStart && i == 0) begin
        start = 1; keyReuse = 1; @(negedge clk); start = 0; keyReuse = 0;
      end
    end
    if (busyStart) begin
      start = 1; keyLong = 1; @(negedge clk); start = 0; keyLong = 0;
    end
    while (!opFinished && guard < 5000) begin @(negedge clk); guard++; end
    repeat (4) @(negedge clk);
    check(doneCnt == 1, busyStart ? "R10" : "R8", 512'(doneCnt), 512'(1));
    check(expBlk.size() == 0, busyStart ? "R10" : "R5", 512'(expBlk.size()), 512'(0));
    expBlk.delete(); expInit.delete(); expTag.delete();
    prevMac = expMac; havePrev = 1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(done === 1'b0, "R1", 512'(done), 512'(0));
    check(coreGo === 1'b0, "R1", 512'(coreGo), 512'(0));
    check(wordReady === 1'b0, "R1", 512'(wordReady), 512'(0));
    check(mac === '0, "R1", 512'(mac), 512'(0));
    rstN = 1;
    @(negedge clk);
    check(wordReady === 1'b0 && done === 1'b0, "R1", 512'({wordReady, done}), 512'(0));
    runOp(0, 0, 5, 16, 3, 0, 1);   // short key
    runOp(1, 0, 0, 32, 1, 0, 2);   // reuse, two text blocks
    runOp(0, 0, 16, 16, 4, 1, 3);  // exact-length key, starts while busy
    runOp(0, 1, 32, 16, 2, 0, 4);  // long key, two key blocks
    runOp(1, 0, 0, 16, 6, 0, 5);   // reuse after long key
    runOp(0, 0, 1, 48, 2, 0, 6);   // one-word key, three text blocks
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule